// File: doc/BRIEF.md
# Clock Synthesizer Divider Configuration Loader

This block keeps the settings of a clock synthesizer: a 9-bit feedback divide value, a 2-bit output divide code and a 2-bit test selector. Two paths can write them. In parallel mode an active-low strobe makes the divide pins pass through while it is low and freezes them when it rises. In serial mode a three-wire port shifts a 14-bit frame into a shift register. A rising serial load strobe copies the frame into the settings. While that strobe stays high, every serial clock edge updates the settings.

All strobes and data pins are oversampled by a fast system clock. Each one passes through a two-flop synchronizer, and the block acts on edges found by comparing the synchronized level with the previous sample. The system clock must run at least four times faster than the serial clock. The settings sit in one register, so all fields change in the same cycle. A status pin shows constant low, the synchronized serial data, the feedback divider output or the synthesizer output clock, as chosen by the test selector. In parallel mode the status pin is held low.

Top module: `synth_cfg_loader`

## Requirements
- R1: The asynchronous active-low `rst_n` clears `m_val`, `n_val` and `t_val` to zero. The master reset `mr` plays no part in this.
- R2: On every rising `sclk` edge the shift register takes `sdata` in at its least significant end. A frame is 14 bits long, sent first bit first, in this order: test bits t1 and t0, then one null slot, then n1 and n0, then m8 down to m0. The null slot must be clocked, and its value never reaches any output.
- R3: With `pload_n` high, a rising edge of `sload` copies the frame fields into `t_val` (frame bits 13:12), `n_val` (bits 10:9) and `m_val` (bits 8:0).
- R4: With `pload_n` high and `sload` low, the settings hold their values, including while new bits are shifted in.
- R5: While `sload` stays high and `pload_n` is high, each rising `sclk` edge updates the settings from the shift register as it stands after that edge.
- R6: While `pload_n` is low, `m_val` and `n_val` follow `m_pins` and `n_pins`, and `t_val` does not change.
- R7: A rising `pload_n` freezes the pin values. Later pin changes are ignored until `pload_n` goes low again or a serial load happens.
- R8: `test_out` is low whenever `pload_n` is low, whatever the test selector holds.
- R9: With `pload_n` high, `test_out` is chosen by `t_val`: 00 gives low, 01 gives the synchronized `sdata`, 10 gives `mdiv_fb`, and 11 gives `fout_clk`.
- R10: `mr` high forces the divider-derived selections (10 and 11) of `test_out` low and leaves `m_val`, `n_val` and `t_val` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| mr | input | 1 | Master reset for the dividers; holds divider-derived status low |
| pload_n | input | 1 | Parallel load strobe, active low |
| m_pins | input | 9 | Parallel feedback divide value |
| n_pins | input | 2 | Parallel output divide code |
| sclk | input | 1 | Serial shift clock |
| sdata | input | 1 | Serial frame data |
| sload | input | 1 | Serial load strobe |
| mdiv_fb | input | 1 | Feedback divider output, for the status mux |
| fout_clk | input | 1 | Synthesizer output clock, for the status mux |
| m_val | output | 9 | Feedback divide value in effect |
| n_val | output | 2 | Output divide code in effect |
| t_val | output | 2 | Test selector in effect |
| test_out | output | 1 | Status pin |

## Verification
The checker assumes that every strobe and data pin stays stable for several system clock cycles around each of its changes. It also assumes that `sdata` settles before `sclk` rises, because the synchronized levels are taken to line up one-to-one with the pin levels. The stimulus meets these assumptions. It drives inputs only one time step after a clock edge, keeps each serial clock half period at four or more system cycles, and sets data three cycles before each rising serial clock edge. It also holds each load strobe level for six cycles.

// File: rtl/scfg_pkg.sv
package scfg_pkg;

  localparam int unsigned TSEL_W = 2;

  typedef enum logic [TSEL_W-1:0] {
    TSEL_LOW   = 2'b00,
    TSEL_SDATA = 2'b01,
    TSEL_MDIV  = 2'b10,
    TSEL_FOUT  = 2'b11
  } tsel_e;

  typedef enum logic [1:0] {
    WR_HOLD  = 2'd0,
    WR_PINS  = 2'd1,
    WR_FRAME = 2'd2
  } wr_src_e;

  // A serial write happens on the load strobe edge, or on a shift edge while the strobe is high.
  function automatic logic serial_write(input logic sload_lvl, input logic sload_rise,
                                        input logic sclk_rise);
    return sload_lvl && (sload_rise || sclk_rise);
  endfunction

  function automatic wr_src_e pick_source(input logic par_mode, input logic ser_wr);
    if (par_mode)    return WR_PINS;
    else if (ser_wr) return WR_FRAME;
    else             return WR_HOLD;
  endfunction

endpackage

// File: rtl/scfg_sync.sv
module scfg_sync #(
  parameter int unsigned      W       = 1,
  parameter int unsigned      STAGES  = 2,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    for (genvar b = 0; b < W; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
        else        chain <= {chain[STAGES-2:0], d[b]};
      end
      assign q[b] = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/scfg_edge.sv
module scfg_edge #(
  parameter int unsigned  W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);

  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RST_VAL;
    else        prev <= lvl;
  end

  assign rise = lvl & ~prev;

endmodule

// File: rtl/scfg_shift.sv
module scfg_shift #(
  parameter int unsigned FRAME = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             din,
  output logic [FRAME-1:0] sr_q,
  output logic [FRAME-1:0] sr_nx
);

  always_comb sr_nx = adv ? {sr_q[FRAME-2:0], din} : sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_nx;
  end

endmodule

// File: rtl/scfg_store.sv
module scfg_store
  import scfg_pkg::*;
#(
  parameter int unsigned M_W = 9,
  parameter int unsigned N_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              par_mode,
  input  logic              sload_lvl,
  input  logic              sload_rise,
  input  logic              sclk_rise,
  input  logic [M_W-1:0]    pin_m,
  input  logic [N_W-1:0]    pin_n,
  input  logic [TSEL_W-1:0] nx_t,
  input  logic [N_W-1:0]    nx_n,
  input  logic [M_W-1:0]    nx_m,
  output logic [M_W-1:0]    m_val,
  output logic [N_W-1:0]    n_val,
  output logic [TSEL_W-1:0] t_val
);

  wr_src_e wr_src;

  always_comb wr_src = pick_source(par_mode, serial_write(sload_lvl, sload_rise, sclk_rise));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_val <= '0;
      n_val <= '0;
      t_val <= '0;
    end else begin
      unique case (wr_src)
        WR_PINS: begin
          m_val <= pin_m;
          n_val <= pin_n;
        end
        WR_FRAME: begin
          m_val <= nx_m;
          n_val <= nx_n;
          t_val <= nx_t;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/scfg_testmux.sv
module scfg_testmux
  import scfg_pkg::*;
(
  input  logic              par_mode,
  input  logic              mr,
  input  logic [TSEL_W-1:0] tsel,
  input  logic              sdata_s,
  input  logic              mdiv_fb,
  input  logic              fout_clk,
  output logic              test_out
);

  always_comb begin
    test_out = 1'b0;
    if (!par_mode) begin
      unique case (tsel)
        TSEL_LOW:   test_out = 1'b0;
        TSEL_SDATA: test_out = sdata_s;
        TSEL_MDIV:  test_out = mdiv_fb & ~mr;
        TSEL_FOUT:  test_out = fout_clk & ~mr;
        default:    test_out = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader
  import scfg_pkg::*;
#(
  parameter int unsigned M_W    = 9,
  parameter int unsigned N_W    = 2,
  parameter int unsigned GAP_W  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mr,
  input  logic              pload_n,
  input  logic [M_W-1:0]    m_pins,
  input  logic [N_W-1:0]    n_pins,
  input  logic              sclk,
  input  logic              sdata,
  input  logic              sload,
  input  logic              mdiv_fb,
  input  logic              fout_clk,
  output logic [M_W-1:0]    m_val,
  output logic [N_W-1:0]    n_val,
  output logic [TSEL_W-1:0] t_val,
  output logic              test_out
);

  // Frame field positions: the last bit shifted lands at bit 0.
  localparam int unsigned M_LSB   = 0;
  localparam int unsigned N_LSB   = M_LSB + M_W;
  localparam int unsigned GAP_LSB = N_LSB + N_W;
  localparam int unsigned T_LSB   = GAP_LSB + GAP_W;
  localparam int unsigned FRAME   = T_LSB + TSEL_W;

  // Synchronized input bundle: {pload_n, sload, sclk, sdata, n_pins, m_pins}
  localparam int unsigned IN_W    = M_W + N_W + 4;
  localparam int unsigned SD_IDX  = M_W + N_W;
  localparam int unsigned SC_IDX  = SD_IDX + 1;
  localparam int unsigned SL_IDX  = SD_IDX + 2;
  localparam int unsigned PL_IDX  = SD_IDX + 3;
  localparam logic [IN_W-1:0] IN_RST = {1'b1, {(IN_W-1){1'b0}}};

  logic [IN_W-1:0]  in_raw, in_s;
  logic [M_W-1:0]   pins_m_s;
  logic [N_W-1:0]   pins_n_s;
  logic             sdata_s, sclk_s, sload_s, pload_s;
  logic             par_mode;
  logic [2:0]       rise;
  logic             sclk_rise, sload_rise, pload_rise;
  logic [FRAME-1:0] sr_q, sr_nx;

  assign in_raw = {pload_n, sload, sclk, sdata, n_pins, m_pins};

  scfg_sync #(.W(IN_W), .STAGES(STAGES), .RST_VAL(IN_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(in_raw), .q(in_s)
  );

  assign pins_m_s = in_s[M_W-1:0];
  assign pins_n_s = in_s[SD_IDX-1:M_W];
  assign sdata_s  = in_s[SD_IDX];
  assign sclk_s   = in_s[SC_IDX];
  assign sload_s  = in_s[SL_IDX];
  assign pload_s  = in_s[PL_IDX];
  assign par_mode = ~pload_s;

  scfg_edge #(.W(3), .RST_VAL(3'b100)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl({pload_s, sload_s, sclk_s}), .rise(rise)
  );

  assign sclk_rise  = rise[0];
  assign sload_rise = rise[1];
  assign pload_rise = rise[2];

  scfg_shift #(.FRAME(FRAME)) u_shift (
    .clk(clk), .rst_n(rst_n), .adv(sclk_rise), .din(sdata_s), .sr_q(sr_q), .sr_nx(sr_nx)
  );

  scfg_store #(.M_W(M_W), .N_W(N_W)) u_store (
    .clk(clk), .rst_n(rst_n), .par_mode(par_mode),
    .sload_lvl(sload_s), .sload_rise(sload_rise), .sclk_rise(sclk_rise),
    .pin_m(pins_m_s), .pin_n(pins_n_s),
    .nx_t(sr_nx[T_LSB +: TSEL_W]), .nx_n(sr_nx[N_LSB +: N_W]), .nx_m(sr_nx[M_LSB +: M_W]),
    .m_val(m_val), .n_val(n_val), .t_val(t_val)
  );

  scfg_testmux u_mux (
    .par_mode(par_mode), .mr(mr), .tsel(t_val), .sdata_s(sdata_s),
    .mdiv_fb(mdiv_fb), .fout_clk(fout_clk), .test_out(test_out)
  );

endmodule

// File: rtl/synth_cfg_loader_chk.sv
module synth_cfg_loader_chk #(
  parameter int unsigned M_W     = 9,
  parameter int unsigned N_W     = 2,
  parameter int unsigned GAP_W   = 1,
  parameter int unsigned GAP_POS = 11,
  parameter int unsigned FRAME   = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mr,
  input logic             par_mode,
  input logic             sload_s,
  input logic             sclk_rise,
  input logic             sload_rise,
  input logic             pload_rise,
  input logic [M_W-1:0]   pins_m_s,
  input logic [N_W-1:0]   pins_n_s,
  input logic [FRAME-1:0] sr_q,
  input logic [FRAME-1:0] sr_nx,
  input logic [M_W-1:0]   m_val,
  input logic [N_W-1:0]   n_val,
  input logic [1:0]       t_val,
  input logic             test_out
);

  assert_reset_zero_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (m_val == '0 && n_val == '0 && t_val == '0));

  assert_frame_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sload_rise && !par_mode) |=>
      ({t_val, $past(sr_nx[GAP_POS +: GAP_W]), n_val, m_val} == $past(sr_nx)));

  assert_serial_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_mode && !sload_s) |=> ($stable(m_val) && $stable(n_val) && $stable(t_val)));

  assert_follow_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sload_s && sclk_rise && !par_mode) |=>
      ({t_val, sr_q[GAP_POS +: GAP_W], n_val, m_val} == sr_q));

  assert_pins_through_R6: assert property (@(posedge clk) disable iff (!rst_n)
    par_mode |=> (m_val == $past(pins_m_s) && n_val == $past(pins_n_s) && $stable(t_val)));

  assert_pins_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pload_rise && !sload_s) |=> ($stable(m_val) && $stable(n_val)));

  assert_test_low_par_R8: assert property (@(posedge clk) disable iff (!rst_n)
    par_mode |-> !test_out);

  assert_mr_masks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mr && !par_mode && t_val[1]) |-> !test_out);

endmodule

bind synth_cfg_loader synth_cfg_loader_chk #(
  .M_W(M_W), .N_W(N_W), .GAP_W(GAP_W), .GAP_POS(GAP_LSB), .FRAME(FRAME)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mr(mr), .par_mode(par_mode), .sload_s(sload_s),
  .sclk_rise(sclk_rise), .sload_rise(sload_rise), .pload_rise(pload_rise),
  .pins_m_s(pins_m_s), .pins_n_s(pins_n_s), .sr_q(sr_q), .sr_nx(sr_nx),
  .m_val(m_val), .n_val(n_val), .t_val(t_val), .test_out(test_out)
);

// File: tb/tb_synth_cfg_loader.sv
module tb_synth_cfg_loader;

  localparam int FRAME = 14;
  localparam int NVEC  = 5;
  // Frames written as {t1,t0, null, n1,n0, m8..m0}
  localparam logic [FRAME-1:0] VEC [NVEC] = '{
    14'b00_0_01_000011001,
    14'b00_1_01_000011001,
    14'b01_1_10_000011111,
    14'b10_0_11_111111111,
    14'b11_0_00_000010000
  };

  logic       clk = 1'b0;
  logic       rst_n, mr, pload_n, sclk, sdata, sload, mdiv_fb, fout_clk;
  logic [8:0] m_pins;
  logic [1:0] n_pins;
  logic [8:0] m_val;
  logic [1:0] n_val;
  logic [1:0] t_val;
  logic       test_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [FRAME-1:0] mdl_sr = '0;
  logic [FRAME-1:0] held;

  always #2 clk = ~clk;

  synth_cfg_loader dut (
    .clk(clk), .rst_n(rst_n), .mr(mr), .pload_n(pload_n), .m_pins(m_pins), .n_pins(n_pins),
    .sclk(sclk), .sdata(sdata), .sload(sload), .mdiv_fb(mdiv_fb), .fout_clk(fout_clk),
    .m_val(m_val), .n_val(n_val), .t_val(t_val), .test_out(test_out)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic chk_cfg(input string tag, input logic [FRAME-1:0] f);
    chk({tag, " m"}, 32'(m_val), 32'(f[8:0]));
    chk({tag, " n"}, 32'(n_val), 32'(f[10:9]));
    chk({tag, " t"}, 32'(t_val), 32'(f[13:12]));
  endtask

  task automatic shift_bit(input logic b);
    sdata = b;
    tick(3);
    sclk = 1'b1;
    mdl_sr = {mdl_sr[FRAME-2:0], b};
    tick(4);
    sclk = 1'b0;
    tick(4);
  endtask

  task automatic shift_frame(input logic [FRAME-1:0] f);
    for (int i = FRAME - 1; i >= 0; i--) shift_bit(f[i]);
  endtask

  task automatic pulse_load();
    sload = 1'b1;
    tick(6);
    sload = 1'b0;
    tick(6);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R3 got hung exp finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mr = 1'b0; pload_n = 1'b1; sclk = 1'b0; sdata = 1'b0; sload = 1'b0;
    mdiv_fb = 1'b0; fout_clk = 1'b0; m_pins = '0; n_pins = '0;
    tick(3);
    chk_cfg("R1 reset", '0);
    chk("R1 reset test_out", 32'(test_out), 0);
    rst_n = 1'b1;
    tick(2);

    // R2/R3/R4: table of serial frames; VEC[1] differs from VEC[0] only in the null slot
    held = '0;
    for (int v = 0; v < NVEC; v++) begin
      shift_frame(VEC[v]);
      chk_cfg("R4 hold while shifting", held);
      pulse_load();
      chk_cfg("R3 R2 frame load", VEC[v]);
      held = VEC[v];
    end

    // R5: transparent while sload high
    sload = 1'b1;
    tick(6);
    chk_cfg("R5 load edge", mdl_sr);
    shift_bit(1'b1);
    tick(2);
    chk_cfg("R5 follow bit 1", mdl_sr);
    shift_bit(1'b0);
    tick(2);
    chk_cfg("R5 follow bit 2", mdl_sr);
    sload = 1'b0;
    tick(6);
    held = mdl_sr;
    shift_bit(1'b1);
    shift_bit(1'b1);
    chk_cfg("R4 hold after sload fall", held);

    // R9: status mux selections
    shift_frame(14'b01_0_00_000011010);
    pulse_load();
    sdata = 1'b1; tick(4);
    chk("R9 sel01 sdata high", 32'(test_out), 1);
    sdata = 1'b0; tick(4);
    chk("R9 sel01 sdata low", 32'(test_out), 0);

    shift_frame(14'b10_0_10_000011011);
    pulse_load();
    mdiv_fb = 1'b1; tick(2);
    chk("R9 sel10 mdiv high", 32'(test_out), 1);
    mdiv_fb = 1'b0; tick(2);
    chk("R9 sel10 mdiv low", 32'(test_out), 0);
    mdiv_fb = 1'b1; mr = 1'b1; tick(4);
    chk("R10 mr masks mdiv", 32'(test_out), 0);
    chk_cfg("R10 mr keeps settings", 14'b10_0_10_000011011);
    mr = 1'b0; mdiv_fb = 1'b0; tick(2);

    shift_frame(14'b00_0_01_000011100);
    pulse_load();
    sdata = 1'b1; mdiv_fb = 1'b1; fout_clk = 1'b1; tick(4);
    chk("R9 sel00 low", 32'(test_out), 0);
    sdata = 1'b0; mdiv_fb = 1'b0; fout_clk = 1'b0;

    shift_frame(14'b11_0_01_000011100);
    pulse_load();
    fout_clk = 1'b1; tick(2);
    chk("R9 sel11 fout high", 32'(test_out), 1);
    fout_clk = 1'b0; tick(2);
    chk("R9 sel11 fout low", 32'(test_out), 0);

    // R6/R7/R8: parallel path
    fout_clk = 1'b1;
    pload_n = 1'b0; m_pins = 9'h0AA; n_pins = 2'd2;
    tick(5);
    chk("R6 pins m", 32'(m_val), 32'h0AA);
    chk("R6 pins n", 32'(n_val), 2);
    chk("R6 t unchanged", 32'(t_val), 3);
    chk("R8 test low in parallel", 32'(test_out), 0);
    m_pins = 9'h155; n_pins = 2'd1;
    tick(5);
    chk("R6 follow m", 32'(m_val), 32'h155);
    chk("R6 follow n", 32'(n_val), 1);
    pload_n = 1'b1;
    tick(5);
    m_pins = 9'h003; n_pins = 2'd3;
    tick(5);
    chk("R7 frozen m", 32'(m_val), 32'h155);
    chk("R7 frozen n", 32'(n_val), 1);
    fout_clk = 1'b0;
    shift_frame(14'b01_1_11_000011110);
    pulse_load();
    chk_cfg("R7 serial overrides", 14'b01_1_11_000011110);

    // R1: asynchronous reset mid-run
    rst_n = 1'b0;
    #1;
    chk_cfg("R1 async clear", '0);
    tick(2);
    rst_n = 1'b1;
    tick(2);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule